// File: doc/BRIEF.md
# Spin Lock Engine with Capped Exponential Backoff

This block sits beside one processor and runs the acquire and release sequence for a single lock word that lives in a shared atomic memory unit. The processor raises an acquire command. The engine then reads the lock word with plain loads until the word shows free. Only then does it spend an atomic test-and-set on the word. If a rival wins the race between that read and the test-and-set, the engine goes quiet for a delay that grows geometrically with each consecutive loss, up to a ceiling, and then resumes plain polling. A release command makes it write zero to the lock word with an ordinary store.

The memory side is a single request port. The engine issues a one-cycle request with an operation code and then waits for a single response, so no more than one access is ever in flight. For reads and test-and-set, the response carries the old lock value. For the store, the response is only an acknowledgement. The acquired output is a registered flag that the processor can use as its permission to enter the critical section.

Top module: `spin_lock_engine`

## Requirements
- R1: After synchronous reset, `acquired_o` and `mem_req_o` are both low and no request is issued until a command arrives.
- R2: An acquire command while idle causes a read request (operation code 0) in the next cycle.
- R3: Whenever a read response returns a nonzero value, the next request is another read (code 0), issued in the cycle after the response. No test-and-set is issued while the word reads busy.
- R4: A read response of zero is followed, in the cycle after it, by exactly one test-and-set request (code 1).
- R5: A test-and-set response of zero raises `acquired_o` in the cycle after the response. The flag then stays high until the release completes.
- R6: A nonzero test-and-set response is followed by exactly D idle cycles and then a read request. For the i-th consecutive failure, D = min(K·C^i, MAX_DELAY).
- R7: The delay never exceeds MAX_DELAY, however many failures occur in a row.
- R8: A successful acquire returns the failure count to zero, so the next first failure again waits min(K·C, MAX_DELAY).
- R9: A release command while the lock is held issues one store-zero request (code 2). `acquired_o` falls in the cycle after that request's response.
- R10: A release command while idle, and an acquire command while the lock is held, are ignored: no request is issued and `acquired_o` keeps its value.
- R11: Each request lasts exactly one cycle, and no new request is issued before the response to the previous one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| acq_start_i | input | 1 | Pulse: begin acquiring the lock |
| rel_start_i | input | 1 | Pulse: release a held lock |
| acquired_o | output | 1 | High while this engine owns the lock |
| mem_req_o | output | 1 | One-cycle request to the atomic memory unit |
| mem_op_o | output | 2 | Request kind: 0 read, 1 test-and-set, 2 store zero |
| mem_rsp_valid_i | input | 1 | Response strobe from the memory unit |
| mem_rsp_data_i | input | DATA_W | Old lock value returned with the response |

## Verification
The hardest state to reach from the ports is a long run of consecutive test-and-set losses. That run is the only path that walks the delay through every growth step and into the ceiling. On a real bus it needs a rival that grabs the lock in the narrow gap between a free-looking read and the atomic access. The bench's memory model injects exactly that race. It takes a count of losses to fake: each read returns zero, but each test-and-set returns one until the count runs out. The scoreboard then checks the idle gap before each read against the expected delay, and a later single loss confirms that the delay has restarted from its first step.

// File: rtl/spl_pkg.sv
package spl_pkg;
  typedef enum logic [1:0] {
    OP_READ   = 2'd0,
    OP_TAS    = 2'd1,
    OP_STORE0 = 2'd2
  } lk_op_e;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_POLL,
    ST_TAS,
    ST_BACKOFF,
    ST_HELD,
    ST_RELEASE
  } lk_state_e;
endpackage

// File: rtl/spl_backoff.sv
module spl_backoff #(
  parameter int K_BASE    = 4,
  parameter int C_GROWTH  = 2,
  parameter int MAX_DELAY = 64
) (
  input  logic clk,
  input  logic rst,
  input  logic fail_i,
  input  logic win_i,
  output logic expire_o
);
  localparam int DLY_W = $clog2(MAX_DELAY + 1);
  localparam int CW    = $clog2(C_GROWTH + 1);
  localparam int PW    = DLY_W + CW;
  localparam int FIRST = (K_BASE * C_GROWTH > MAX_DELAY) ? MAX_DELAY : K_BASE * C_GROWTH;

  logic [DLY_W-1:0] step_q, step_d, cnt_q;
  logic [PW-1:0]    prod;

  // next step = step * C, clamped at the ceiling
  always_comb begin
    prod   = PW'(step_q) * PW'(C_GROWTH);
    step_d = (prod > PW'(MAX_DELAY)) ? DLY_W'(MAX_DELAY) : prod[DLY_W-1:0];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      step_q <= DLY_W'(FIRST);
      cnt_q  <= '0;
    end else begin
      if (win_i) begin
        step_q <= DLY_W'(FIRST);
      end else if (fail_i) begin
        step_q <= step_d;
      end
      if (fail_i) begin
        cnt_q <= step_q;
      end else if (cnt_q != '0) begin
        cnt_q <= cnt_q - 1'b1;
      end
    end
  end

  assign expire_o = (cnt_q == DLY_W'(1));

  // R7: the loaded delay stays within the ceiling
  always_ff @(posedge clk) begin
    if (!rst) begin
      assert_step_capped_R7: assert (step_q <= DLY_W'(MAX_DELAY) && cnt_q <= DLY_W'(MAX_DELAY));
    end
  end

  // R6: a loaded countdown runs down by one each cycle
  assert_count_down_R6: assert property (@(posedge clk) disable iff (rst)
    (!fail_i && cnt_q != '0) |=> (cnt_q == $past(cnt_q) - 1'b1));
endmodule

// File: rtl/spl_ctrl.sv
module spl_ctrl
  import spl_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              acq_start_i,
  input  logic              rel_start_i,
  input  logic              mem_rsp_valid_i,
  input  logic [DATA_W-1:0] mem_rsp_data_i,
  input  logic              expire_i,
  output logic              fail_o,
  output logic              win_o,
  output logic              acquired_o,
  output logic              mem_req_o,
  output lk_op_e            mem_op_o
);
  lk_state_e state_q;
  logic      rsp_free;

  assign rsp_free = (mem_rsp_data_i == '0);
  assign fail_o   = (state_q == ST_TAS) && mem_rsp_valid_i && !rsp_free;
  assign win_o    = (state_q == ST_TAS) && mem_rsp_valid_i && rsp_free;

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q    <= ST_IDLE;
      mem_req_o  <= 1'b0;
      mem_op_o   <= OP_READ;
      acquired_o <= 1'b0;
    end else begin
      mem_req_o <= 1'b0;
      unique case (state_q)
        ST_IDLE: if (acq_start_i) begin
          state_q   <= ST_POLL;
          mem_req_o <= 1'b1;
          mem_op_o  <= OP_READ;
        end
        ST_POLL: if (mem_rsp_valid_i) begin
          mem_req_o <= 1'b1;
          if (rsp_free) begin
            state_q  <= ST_TAS;
            mem_op_o <= OP_TAS;
          end else begin
            mem_op_o <= OP_READ;
          end
        end
        ST_TAS: if (mem_rsp_valid_i) begin
          if (rsp_free) begin
            state_q    <= ST_HELD;
            acquired_o <= 1'b1;
          end else begin
            state_q <= ST_BACKOFF;
          end
        end
        ST_BACKOFF: if (expire_i) begin
          state_q   <= ST_POLL;
          mem_req_o <= 1'b1;
          mem_op_o  <= OP_READ;
        end
        ST_HELD: if (rel_start_i) begin
          state_q   <= ST_RELEASE;
          mem_req_o <= 1'b1;
          mem_op_o  <= OP_STORE0;
        end
        ST_RELEASE: if (mem_rsp_valid_i) begin
          state_q    <= ST_IDLE;
          acquired_o <= 1'b0;
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assert_req_pulse_R11: assert property (@(posedge clk) disable iff (rst)
    mem_req_o |=> !mem_req_o);

  assert_tas_after_free_R4: assert property (@(posedge clk) disable iff (rst)
    (mem_req_o && mem_op_o == OP_TAS) |-> $past(mem_rsp_valid_i && mem_rsp_data_i == '0));

  assert_busy_reads_R3: assert property (@(posedge clk) disable iff (rst)
    (mem_req_o && $past(mem_rsp_valid_i && mem_rsp_data_i != '0)) |-> (mem_op_o == OP_READ));

  assert_acq_rise_R5: assert property (@(posedge clk) disable iff (rst)
    $rose(acquired_o) |-> $past(mem_rsp_valid_i && mem_rsp_data_i == '0));

  assert_acq_fall_R9: assert property (@(posedge clk) disable iff (rst)
    $fell(acquired_o) |-> $past(mem_rsp_valid_i));

  assert_held_quiet_R10: assert property (@(posedge clk) disable iff (rst)
    (acquired_o && $past(acquired_o) && $past(state_q == ST_HELD) && !$past(rel_start_i)) |-> !mem_req_o);
endmodule

// File: rtl/spin_lock_engine.sv
module spin_lock_engine #(
  parameter int DATA_W    = 32,
  parameter int K_BASE    = 4,
  parameter int C_GROWTH  = 2,
  parameter int MAX_DELAY = 64
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              acq_start_i,
  input  logic              rel_start_i,
  output logic              acquired_o,
  output logic              mem_req_o,
  output logic [1:0]        mem_op_o,
  input  logic              mem_rsp_valid_i,
  input  logic [DATA_W-1:0] mem_rsp_data_i
);
  import spl_pkg::*;

  logic   fail, win, expire;
  lk_op_e op;

  spl_ctrl #(.DATA_W(DATA_W)) u_ctrl (
    .clk             (clk),
    .rst             (rst),
    .acq_start_i     (acq_start_i),
    .rel_start_i     (rel_start_i),
    .mem_rsp_valid_i (mem_rsp_valid_i),
    .mem_rsp_data_i  (mem_rsp_data_i),
    .expire_i        (expire),
    .fail_o          (fail),
    .win_o           (win),
    .acquired_o      (acquired_o),
    .mem_req_o       (mem_req_o),
    .mem_op_o        (op)
  );

  spl_backoff #(
    .K_BASE    (K_BASE),
    .C_GROWTH  (C_GROWTH),
    .MAX_DELAY (MAX_DELAY)
  ) u_backoff (
    .clk      (clk),
    .rst      (rst),
    .fail_i   (fail),
    .win_i    (win),
    .expire_o (expire)
  );

  assign mem_op_o = op;
endmodule

// File: tb/sim_spin_lock_engine.sv
module sim_spin_lock_engine;
  localparam int DATA_W = 32;

  logic              clk = 1'b0;
  logic              rst = 1'b1;
  logic              acq_start = 1'b0, rel_start = 1'b0;
  logic              acquired, mem_req, rsp_valid;
  logic [1:0]        mem_op;
  logic [DATA_W-1:0] rsp_data;

  always #5 clk = ~clk;

  spin_lock_engine #(.DATA_W(DATA_W), .K_BASE(4), .C_GROWTH(2), .MAX_DELAY(64)) u0 (
    .clk (clk), .rst (rst),
    .acq_start_i (acq_start), .rel_start_i (rel_start),
    .acquired_o (acquired), .mem_req_o (mem_req), .mem_op_o (mem_op),
    .mem_rsp_valid_i (rsp_valid), .mem_rsp_data_i (rsp_data)
  );

  int n_chk = 0, n_fail = 0, cyc = 0, last_rsp = 0;
  int word = 0, rival_reads = 0, steal = 0;

  typedef struct { logic [1:0] op; int gap; string req; } exp_t;
  exp_t q[$];

  task automatic check(input bit ok, input string req, input int act, input int expv);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, expv);
    end
  endtask

  task automatic expect_req(input logic [1:0] op, input int gap, input string req);
    exp_t e;
    e.op = op; e.gap = gap; e.req = req;
    q.push_back(e);
  endtask

  task automatic pulse(input bit is_acq);
    @(negedge clk);
    if (is_acq) acq_start = 1'b1; else rel_start = 1'b1;
    @(negedge clk);
    acq_start = 1'b0; rel_start = 1'b0;
  endtask

  task automatic wait_acq(input logic lvl, input string req);
    int n = 0;
    while (acquired !== lvl && n < 2000) begin @(negedge clk); n++; end
    check(acquired === lvl, req, int'(acquired), int'(lvl));
  endtask

  // memory model: one-cycle response latency
  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (rst) rsp_valid <= 1'b0;
    else begin
      rsp_valid <= 1'b0;
      if (mem_req) begin
        rsp_valid <= 1'b1;
        case (mem_op)
          2'd0: if (rival_reads > 0) begin rsp_data <= 1; rival_reads = rival_reads - 1; end
                else if (steal > 0) rsp_data <= 0;
                else rsp_data <= DATA_W'(word);
          2'd1: if (steal > 0) begin rsp_data <= 1; steal = steal - 1; end
                else begin rsp_data <= DATA_W'(word); word = 1; end
          default: begin word = 0; rsp_data <= 0; end
        endcase
      end
    end
  end

  // monitor / scoreboard
  always @(negedge clk) begin
    if (!rst) begin
      if (rsp_valid) last_rsp = cyc;
      if (mem_req) begin
        if (q.size() == 0) begin
          check(1'b0, "R10/R11 unexpected request", int'(mem_op), -1);
        end else begin
          exp_t e;
          e = q.pop_front();
          check(mem_op == e.op, {e.req, " op"}, int'(mem_op), int'(e.op));
          if (e.gap != 0) check(cyc - last_rsp == e.gap, {e.req, " gap"}, cyc - last_rsp, e.gap);
        end
      end
    end
  end

  task automatic drained(input string req);
    check(q.size() == 0, req, q.size(), 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog R11: actual timeout expected completion");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1: reset state
    check(acquired == 1'b0, "R1 acquired", int'(acquired), 0);
    check(mem_req == 1'b0, "R1 mem_req", int'(mem_req), 0);

    // R10: release while idle is ignored
    pulse(1'b0);
    repeat (5) @(negedge clk);
    check(acquired == 1'b0, "R10 release in idle", int'(acquired), 0);

    // R2, R4, R5: free lock
    expect_req(2'd0, 0, "R2 first read");
    expect_req(2'd1, 1, "R4 tas after free read");
    pulse(1'b1);
    wait_acq(1'b1, "R5 acquired on free lock");
    drained("R4 sequence done");
    check(word == 1, "R5 word set", word, 1);

    // R10: acquire while held is ignored
    pulse(1'b1);
    repeat (6) @(negedge clk);
    check(acquired == 1'b1, "R10 acquire while held", int'(acquired), 1);

    // R9: release
    expect_req(2'd2, 0, "R9 store zero");
    pulse(1'b0);
    wait_acq(1'b0, "R9 acquired falls");
    check(word == 0, "R9 word cleared", word, 0);
    drained("R9 sequence done");

    // R3: busy lock polled by plain reads
    rival_reads = 3;
    expect_req(2'd0, 0, "R3 read");
    for (int i = 0; i < 3; i++) expect_req(2'd0, 1, "R3 busy reread");
    expect_req(2'd1, 1, "R4 tas after busy");
    pulse(1'b1);
    wait_acq(1'b1, "R5 acquired after busy");
    drained("R3 sequence done");
    expect_req(2'd2, 0, "R9 store zero");
    pulse(1'b0);
    wait_acq(1'b0, "R9 released");

    // R6, R7: five consecutive losses, delays 8,16,32,64,64
    steal = 5;
    expect_req(2'd0, 0, "R6 read");
    expect_req(2'd1, 1, "R6 tas");
    expect_req(2'd0, 9, "R6 delay 8");
    expect_req(2'd1, 1, "R6 tas");
    expect_req(2'd0, 17, "R6 delay 16");
    expect_req(2'd1, 1, "R6 tas");
    expect_req(2'd0, 33, "R6 delay 32");
    expect_req(2'd1, 1, "R6 tas");
    expect_req(2'd0, 65, "R7 delay 64");
    expect_req(2'd1, 1, "R6 tas");
    expect_req(2'd0, 65, "R7 delay capped");
    expect_req(2'd1, 1, "R6 final tas");
    pulse(1'b1);
    wait_acq(1'b1, "R5 acquired after losses");
    drained("R7 sequence done");
    expect_req(2'd2, 0, "R9 store zero");
    pulse(1'b0);
    wait_acq(1'b0, "R9 released");

    // R8: failure count restarts after a win
    steal = 1;
    expect_req(2'd0, 0, "R8 read");
    expect_req(2'd1, 1, "R8 tas");
    expect_req(2'd0, 9, "R8 delay back to 8");
    expect_req(2'd1, 1, "R8 tas");
    pulse(1'b1);
    wait_acq(1'b1, "R8 acquired");
    drained("R8 sequence done");

    repeat (4) @(negedge clk);
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule